// File: doc/BRIEF.md
# Framed Dual-Pattern Serial Detector

This block watches a single serial bit stream and divides it into back-to-back four-bit frames that do not overlap. Each bit is consumed only in a cycle where the qualifier `bit_valid` is high. On the fourth bit of a frame, the output `z_out` rises in that same cycle if the frame read `0101` or `1001`. The first bit received is the leftmost. The machine then goes back to its frame-start state, whatever the frame held. The output is Mealy: it depends on the present state and on the bit that is on `x_in` right now.

The state set is already reduced. After two bits, the prefixes `01` and `10` still need the same tail `01`, so they share one state. Prefixes that can no longer match (`00`, `11`, or a wrong third bit) go to dead states. These states only count off the rest of the frame. The parameter `ONE_HOT` chooses how the seven states are stored: as a three-bit binary index, or as seven flip-flops with exactly one of them set. The behaviour at the ports is the same for both choices.

Top module: `frame_pattern_detector`

## Requirements
- R1: A synchronous active-high `rst` puts the machine at frame start and holds `z_out` at 0 while `rst` is high. This is true even if `bit_valid` is high in that cycle. The next valid bit after reset is the first bit of a new frame.
- R2: Valid bits are grouped four at a time into disjoint frames. After the fourth valid bit of a frame, the next valid bit always starts a new frame, whatever the earlier frame contained.
- R3: `z_out` is 1 during the fourth valid bit of a frame whose bits, in arrival order, are 0,1,0,1.
- R4: `z_out` is 1 during the fourth valid bit of a frame whose bits, in arrival order, are 1,0,0,1.
- R5: `z_out` is 0 during the fourth valid bit of a frame holding any of the other fourteen four-bit sequences.
- R6: `z_out` is 0 in every cycle where `bit_valid` is low, and in every cycle where the present bit is not the fourth bit of its frame.
- R7: While `bit_valid` is low, `x_in` is ignored, and both the frame position and the match state hold. Idle gaps anywhere inside a frame do not change the result of that frame.
- R8: With `ONE_HOT` = 1, each state has its own flip-flop and exactly one flip-flop is set in every cycle after reset. `z_out` matches the `ONE_HOT` = 0 build cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to frame start |
| bit_valid | input | 1 | High when `x_in` carries a bit to consume |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | Mealy match flag, high on the fourth bit of a matching frame |

## Verification
Reset and frame completion can fall in the same cycle. The bench brings this about by driving `rst` high together with a valid fourth bit that would complete `0101`. It expects `z_out` to stay 0, and it expects the very next frame to be detected from its first bit. Frame completion and a qualifier gap can also meet: a low `bit_valid` is placed where the fourth bit would have come. In that case `z_out` must stay 0 and the detection must move to the next valid bit. A reference model in the bench follows every cycle. Both encodings run side by side and are judged against it.

// File: rtl/fpd_pkg.sv
`timescale 1ns/1ps
package fpd_pkg;
  // Reduced state set; binary index equals enum value, one-hot bit position equals enum value
  localparam int FPD_NSTATES   = 7;
  localparam int FPD_IDX_W     = 3;
  localparam int FPD_FRAME_LEN = 4;

  typedef enum logic [FPD_IDX_W-1:0] {
    ST_IDLE  = 3'd0,  // frame start, nothing consumed
    ST_LEAD0 = 3'd1,  // first bit was 0
    ST_LEAD1 = 3'd2,  // first bit was 1
    ST_MID   = 3'd3,  // prefix 01 or 10 (merged): needs 01
    ST_NEAR  = 3'd4,  // prefix 010 or 100: needs 1
    ST_DEAD2 = 3'd5,  // two bits in, no match possible
    ST_DEAD3 = 3'd6   // three bits in, no match possible
  } fpd_state_e;

  function automatic fpd_state_e fpd_step(input fpd_state_e s, input logic x);
    case (s)
      ST_IDLE:  return x ? ST_LEAD1 : ST_LEAD0;
      ST_LEAD0: return x ? ST_MID   : ST_DEAD2;
      ST_LEAD1: return x ? ST_DEAD2 : ST_MID;
      ST_MID:   return x ? ST_DEAD3 : ST_NEAR;
      ST_DEAD2: return ST_DEAD3;
      default:  return ST_IDLE;   // ST_NEAR, ST_DEAD3 close the frame
    endcase
  endfunction

  function automatic logic fpd_hit(input fpd_state_e s, input logic x);
    return (s == ST_NEAR) && x;
  endfunction
endpackage

// File: rtl/fpd_frame_pos.sv
`timescale 1ns/1ps
module fpd_frame_pos #(
  parameter int FRAME_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic at_start,
  output logic at_last
);
  localparam int PW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst)          pos <= '0;
    else if (advance) pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end

  assign at_start = (pos == '0);
  assign at_last  = (pos == LAST);

  assert_pos_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pos));
  assert_pos_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (advance && at_last) |=> at_start);
endmodule

// File: rtl/fpd_state_store.sv
`timescale 1ns/1ps
module fpd_state_store
  import fpd_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  fpd_state_e nxt,
  output fpd_state_e cur
);
  generate
    if (ONE_HOT) begin : g_hot
      logic [FPD_NSTATES-1:0] hot;
      logic [FPD_NSTATES-1:0] hot_nxt;

      always_comb begin
        hot_nxt = '0;
        hot_nxt[nxt] = 1'b1;
      end

      always_ff @(posedge clk) begin
        if (rst)       hot <= FPD_NSTATES'(1) << ST_IDLE;
        else if (load) hot <= hot_nxt;
      end

      always_comb begin
        cur = ST_IDLE;
        for (int i = 0; i < FPD_NSTATES; i++)
          if (hot[i]) cur = fpd_state_e'(FPD_IDX_W'(i));
      end

      assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(hot) == 1);
    end else begin : g_bin
      fpd_state_e idx;
      always_ff @(posedge clk) begin
        if (rst)       idx <= ST_IDLE;
        else if (load) idx <= nxt;
      end
      assign cur = idx;
    end
  endgenerate

  assert_state_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur));
endmodule

// File: rtl/frame_pattern_detector.sv
`timescale 1ns/1ps
module frame_pattern_detector
  import fpd_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic x_in,
  output logic z_out
);
  fpd_state_e state_now;
  fpd_state_e state_next;
  logic       frame_start;
  logic       frame_last;
  logic       bit_take;

  assign bit_take   = bit_valid & ~rst;
  assign state_next = fpd_step(state_now, x_in);

  fpd_frame_pos #(.FRAME_LEN(FPD_FRAME_LEN)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .advance  (bit_take),
    .at_start (frame_start),
    .at_last  (frame_last)
  );

  fpd_state_store #(.ONE_HOT(ONE_HOT)) u_state (
    .clk  (clk),
    .rst  (rst),
    .load (bit_take),
    .nxt  (state_next),
    .cur  (state_now)
  );

  assign z_out = bit_take & frame_last & fpd_hit(state_now, x_in);

  // Frame counter and state machine are separate logic; they must agree on frame start
  assert_start_agree_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start == (state_now == ST_IDLE));
  assert_frame_return_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && frame_last) |=> (state_now == ST_IDLE));
  assert_z_gated_R6: assert property (@(posedge clk) disable iff (rst)
    z_out |-> (bit_valid && frame_last));
  assert_z_needs_one_R3: assert property (@(posedge clk) disable iff (rst)
    z_out |-> x_in);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> !z_out);
endmodule

// File: tb/frame_pattern_detector_test.sv
`timescale 1ns/1ps
module frame_pattern_detector_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic x_in = 1'b0;
  logic z_bin, z_hot;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  // reference model state
  int       ref_cnt = 0;
  bit [3:0] ref_sh  = '0;
  bit [15:0] lfsr   = 16'hACE1;

  always #2 clk = ~clk;   // 250 MHz

  frame_pattern_detector #(.ONE_HOT(1'b0)) uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .x_in(x_in), .z_out(z_bin));
  frame_pattern_detector #(.ONE_HOT(1'b1)) uut_oh (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .x_in(x_in), .z_out(z_hot));

  // Driver: applies one cycle of stimulus and pushes the expected z
  task automatic drive(input bit r, input bit v, input bit x);
    bit    e;
    string t;
    @(negedge clk);
    rst = r; bit_valid = v; x_in = x;
    if (r) begin
      e = 1'b0; t = "R1"; ref_cnt = 0;
    end else if (!v) begin
      e = 1'b0; t = "R7";
    end else begin
      ref_sh = {ref_sh[2:0], x};
      if (ref_cnt == 3) begin
        e = (ref_sh == 4'b0101) || (ref_sh == 4'b1001);
        t = (ref_sh == 4'b0101) ? "R3" : (ref_sh == 4'b1001) ? "R4" : "R5";
      end else begin
        e = 1'b0; t = "R6";
      end
      ref_cnt = (ref_cnt + 1) % 4;
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic frame(input bit [3:0] f);
    for (int i = 3; i >= 0; i--) drive(1'b0, 1'b1, f[i]);
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Monitor: pops expectations and compares both encodings just before the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() != 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (z_bin !== e) begin
          fails++;
          $display("FAIL %s binary: z=%b expected %b at %0t", t, z_bin, e, $time);
        end
        checks++;
        if (z_hot !== e) begin
          fails++;
          $display("FAIL %s/R8 one-hot: z=%b expected %b at %0t", t, z_hot, e, $time);
        end
      end
    end
  end

  initial begin
    // R1: reset cycles, then first frame detected straight away
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1);
    frame(4'b0101);                 // R3
    frame(4'b1001);                 // R4
    // R5: every pattern, back to back (R2)
    for (int p = 0; p < 16; p++) frame(4'(p));
    // R7: gaps inside a frame, with x toggling while invalid
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);        // R6: would-be fourth bit, invalid
    drive(1'b0, 1'b1, 1'b1);        // completes 0101 here
    // R1: reset collides with a completing fourth bit
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b1);
    frame(4'b1001);
    // R1: reset mid-frame
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    frame(4'b0101);
    // R2/R7: long pseudo-random run with random gaps
    for (int i = 0; i < 3000; i++) begin
      bit v;
      bit x;
      v = rnd() | rnd();
      x = rnd();
      drive(1'b0, v, x);
    end
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule